// File: doc/BRIEF.md
# Parallel Flash Bus Mode Controller

This block is the control side of a byte-wide parallel flash device as a microprocessor bus sees it. Four active-low pins are decoded into a bus mode: power-down and reset (`rp_n`), chip select (`ce_n`), read strobe (`oe_n`) and write strobe (`we_n`). The modes are read, output disable, standby, deep power-down and write. The block also produces the enable for a tri-state 8-bit data bus. A command write selects which source a read returns: the storage array, the identifier codes or the status byte. A small register-file stub stands in for the cell array. It accepts byte program and block erase operations, which run for a parameterized number of clock cycles.

Low `rp_n` acts as both power-up reset and deep power-down. It clears the command state and aborts any running operation, and it marks the block that operation was altering as corrupt. When `rp_n` rises again, two cycle counters start. One keeps the data bus undriven until reads are valid. The other rejects command writes until its own interval has passed. The pins are sampled on `clk`. A command is taken on the rising edge of `we_n` while `ce_n` is low.

Top module: `flashbus_ctrl`

## Requirements
- R1: `dout_en` is high only when `rp_n`=1, `ce_n`=0, `oe_n`=0 and `we_n`=1, and the read wakeup has elapsed. `bus_mode` encodes the modes as 0 power-down, 1 standby, 2 output disable, 3 read and 4 write. Power-down takes priority, then standby, then write (`we_n`=0), then output disable.
- R2: With the chip selected and `oe_n`=1, `dout_en` is 0.
- R3: With `ce_n`=1, `dout_en` is 0 whatever `oe_n` is.
- R4: With `rp_n`=0, `dout_en` is 0 and `bus_mode` is 0.
- R5: Command bytes select the read source: FFh selects the array, 90h the identifier and 70h the status byte. Power-up selects the array.
- R6: In identifier mode, `addr[0]`=0 reads 89h. `addr[0]`=1 reads 94h when BOOT_TOP=1 and 95h when BOOT_TOP=0.
- R7: The status byte has bit 7 set when ready and bit 3 set after a refused program or erase; its other bits are 0. Command 50h clears bit 3. After `rp_n` returns high, the status byte is 80h and the read source is the array.
- R8: Command 40h followed by a data write stores `din` at `addr` after PROG_CYC cycles. During that time, status bit 7 is 0 and further writes are ignored. Reads then return status.
- R9: A write of command 20h erases the block selected by the upper `addr` bits to FFh after ERASE_CYC cycles, and it makes that block valid again.
- R10: With `vpp_ok`=0, a program or erase leaves the array unchanged and sets status bit 3 (status reads 88h). Reads still work.
- R11: Raising `ce_n` during a program or erase does not stop it. The operation completes.
- R12: If `rp_n` goes low during a program or erase, the operation is aborted. Array reads from the block it was altering then return INVALID_BYTE until that block is erased.
- R13: After `rp_n` rises, `dout_en` stays 0 until READ_WAKE rising clock edges with `rp_n`=1 have passed.
- R14: A command write whose capturing edge is within the first WRITE_WAKE edges after `rp_n` rises is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rp_n | input | 1 | Reset / deep power-down, active low |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| vpp_ok | input | 1 | Program voltage valid |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data / command byte |
| dout | output | 8 | Read data |
| dout_en | output | 1 | Tri-state enable for the data bus |
| bus_mode | output | 3 | Decoded bus mode |

## Verification
The hardest state to reach is a power-down that lands in the middle of a running erase. It must be followed by the two wakeup windows, with a command write aimed inside the write lockout. To get there, the bench first sets the status error bit with a refused program. It then starts an erase and drops `rp_n` a few cycles later. It raises `rp_n` with the bus already in read configuration, so `dout_en` can be checked edge by edge. Finally, it times a status command so that its capturing edge falls inside the write lockout. A following array read from the aborted block shows, in one byte, both that the command was ignored and that the block was invalidated.

// File: rtl/flashbus_pkg.sv
package flashbus_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      BM_PWRDN   = 3'd0,
      BM_STANDBY = 3'd1,
      BM_OUTDIS  = 3'd2,
      BM_READ    = 3'd3,
      BM_WRITE   = 3'd4
   } bus_mode_t;

   typedef enum logic [1:0] {
      SRC_ARRAY  = 2'd0,
      SRC_IDENT  = 2'd1,
      SRC_STATUS = 2'd2
   } rd_src_t;

   typedef enum logic {
      OP_PROG  = 1'b0,
      OP_ERASE = 1'b1
   } op_kind_t;

   localparam logic [BYTE_W-1:0] CMD_ARRAY  = 8'hFF;
   localparam logic [BYTE_W-1:0] CMD_IDENT  = 8'h90;
   localparam logic [BYTE_W-1:0] CMD_STATUS = 8'h70;
   localparam logic [BYTE_W-1:0] CMD_CLEAR  = 8'h50;
   localparam logic [BYTE_W-1:0] CMD_PROG   = 8'h40;
   localparam logic [BYTE_W-1:0] CMD_ERASE  = 8'h20;

   localparam logic [BYTE_W-1:0] MFR_CODE     = 8'h89;
   localparam logic [BYTE_W-1:0] DEV_CODE_TOP = 8'h94;
   localparam logic [BYTE_W-1:0] DEV_CODE_BOT = 8'h95;
endpackage

// File: rtl/flashbus_wake_cnt.sv
module flashbus_wake_cnt #(
   parameter int LIMIT = 4
) (
   input  logic clk,
   input  logic rp_n,
   output logic ok
);
   localparam int CW = $clog2(LIMIT + 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("flashbus_wake_cnt: LIMIT must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rp_n)
         cnt <= CW'(LIMIT);
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign ok = (cnt == '0);

   // R13
   wake_hold_chk: assert property (@(posedge clk) disable iff (!rp_n)
      $rose(rp_n) |-> !ok);
endmodule

// File: rtl/flashbus_mode_dec.sv
module flashbus_mode_dec
   import flashbus_pkg::*;
(
   input  logic      rp_n,
   input  logic      ce_n,
   input  logic      oe_n,
   input  logic      we_n,
   input  logic      rd_ok,
   output bus_mode_t mode,
   output logic      drive
);
   always_comb begin
      if (!rp_n)      mode = BM_PWRDN;
      else if (ce_n)  mode = BM_STANDBY;
      else if (!we_n) mode = BM_WRITE;
      else if (oe_n)  mode = BM_OUTDIS;
      else            mode = BM_READ;
   end

   assign drive = (mode == BM_READ) && rd_ok;
endmodule

// File: rtl/flashbus_cmd_fsm.sv
module flashbus_cmd_fsm
   import flashbus_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int PROG_CYC  = 5,
   parameter int ERASE_CYC = 12
) (
   input  logic              clk,
   input  logic              rp_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              vpp_ok,
   input  logic              wr_ok,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] din,
   output rd_src_t           rd_src,
   output logic [BYTE_W-1:0] status,
   output logic              commit_prog,
   output logic              commit_erase,
   output logic              abort,
   output logic [ADDR_W-1:0] op_addr,
   output logic [BYTE_W-1:0] op_data
);
   localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
   localparam int CW      = $clog2(MAX_CYC + 1);

   if (PROG_CYC < 1 || ERASE_CYC < 1) begin : g_bad_cyc
      $error("flashbus_cmd_fsm: operation lengths must be at least 1");
   end

   logic          we_prev;
   logic          busy;
   logic          vpp_err;
   logic          prog_arm;
   logic [CW-1:0] op_cnt;
   op_kind_t      op_kind;
   logic          we_rise;
   logic          wr_stb;
   logic          done;

   assign we_rise = rp_n && !we_prev && we_n && !ce_n;
   assign wr_stb  = we_rise && wr_ok;
   assign done    = rp_n && busy && (op_cnt == CW'(1));

   always_ff @(posedge clk) begin
      if (!rp_n) begin
         we_prev  <= 1'b1;
         rd_src   <= SRC_ARRAY;
         busy     <= 1'b0;
         vpp_err  <= 1'b0;
         prog_arm <= 1'b0;
         op_cnt   <= '0;
         op_kind  <= OP_PROG;
      end else begin
         we_prev <= we_n;
         if (busy) begin
            op_cnt <= op_cnt - 1'b1;
            if (op_cnt == CW'(1))
               busy <= 1'b0;
         end else if (wr_stb) begin
            if (prog_arm) begin
               prog_arm <= 1'b0;
               rd_src   <= SRC_STATUS;
               if (vpp_ok) begin
                  busy    <= 1'b1;
                  op_cnt  <= CW'(PROG_CYC);
                  op_kind <= OP_PROG;
                  op_addr <= addr;
                  op_data <= din;
               end else begin
                  vpp_err <= 1'b1;
               end
            end else begin
               case (din)
                  CMD_ARRAY:  rd_src <= SRC_ARRAY;
                  CMD_IDENT:  rd_src <= SRC_IDENT;
                  CMD_STATUS: rd_src <= SRC_STATUS;
                  CMD_CLEAR:  vpp_err <= 1'b0;
                  CMD_PROG: begin
                     prog_arm <= 1'b1;
                     rd_src   <= SRC_STATUS;
                  end
                  CMD_ERASE: begin
                     rd_src <= SRC_STATUS;
                     if (vpp_ok) begin
                        busy    <= 1'b1;
                        op_cnt  <= CW'(ERASE_CYC);
                        op_kind <= OP_ERASE;
                        op_addr <= addr;
                     end else begin
                        vpp_err <= 1'b1;
                     end
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   assign status       = {~busy, 3'b000, vpp_err, 3'b000};
   assign commit_prog  = done && (op_kind == OP_PROG);
   assign commit_erase = done && (op_kind == OP_ERASE);
   assign abort        = !rp_n && busy;

   // R7
   wake_clear_chk: assert property (@(posedge clk) disable iff (!rp_n)
      $rose(rp_n) |-> (!busy && !vpp_err && rd_src == SRC_ARRAY));

   // R14
   early_write_chk: assert property (@(posedge clk) disable iff (!rp_n)
      (we_rise && !wr_ok) |=> ($stable(rd_src) && !busy));

   // R8
   busy_count_chk: assert property (@(posedge clk) disable iff (!rp_n)
      busy |-> (op_cnt != '0));

   // R11
   busy_runs_chk: assert property (@(posedge clk) disable iff (!rp_n)
      (busy && op_cnt > CW'(1)) |=> busy);
endmodule

// File: rtl/flashbus_store.sv
module flashbus_store
   import flashbus_pkg::*;
#(
   parameter int                ADDR_W       = 4,
   parameter int                BLK_AW       = 1,
   parameter bit                BOOT_TOP     = 1'b1,
   parameter logic [BYTE_W-1:0] INVALID_BYTE = 8'h00
) (
   input  logic              clk,
   input  logic              rp_n,
   input  logic [ADDR_W-1:0] addr,
   input  rd_src_t           rd_src,
   input  logic [BYTE_W-1:0] status,
   input  logic              commit_prog,
   input  logic              commit_erase,
   input  logic              abort,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [BYTE_W-1:0] op_data,
   output logic [BYTE_W-1:0] rdata
);
   localparam int DEPTH     = 1 << ADDR_W;
   localparam int NBLK      = 1 << BLK_AW;
   localparam int BLK_SHIFT = ADDR_W - BLK_AW;

   if (BLK_AW < 0 || BLK_AW >= ADDR_W) begin : g_bad_blk
      $error("flashbus_store: BLK_AW must be below ADDR_W");
   end

   logic [BYTE_W-1:0] mem   [DEPTH];
   logic [NBLK-1:0]   valid;
   logic [BYTE_W-1:0] dev_code;
   logic [BLK_AW-1:0] op_blk;
   logic [BLK_AW-1:0] rd_blk;

   if (BOOT_TOP) begin : g_top_boot
      assign dev_code = DEV_CODE_TOP;
   end else begin : g_bot_boot
      assign dev_code = DEV_CODE_BOT;
   end

   assign op_blk = op_addr[ADDR_W-1:BLK_SHIFT];
   assign rd_blk = addr[ADDR_W-1:BLK_SHIFT];

   always_ff @(posedge clk) begin
      if (abort) begin
         valid[op_blk] <= 1'b0;
      end else if (commit_erase) begin
         valid[op_blk] <= 1'b1;
         for (int i = 0; i < DEPTH; i++) begin
            if ((i >> BLK_SHIFT) == int'(op_blk))
               mem[i] <= '1;
         end
      end else if (commit_prog) begin
         mem[op_addr] <= op_data;
      end
   end

   always_comb begin
      case (rd_src)
         SRC_IDENT:  rdata = addr[0] ? dev_code : MFR_CODE;
         SRC_STATUS: rdata = status;
         default:    rdata = valid[rd_blk] ? mem[addr] : INVALID_BYTE;
      endcase
   end

   // R9
   erase_valid_chk: assert property (@(posedge clk) disable iff (!rp_n)
      commit_erase |=> valid[$past(op_blk)]);
endmodule

// File: rtl/flashbus_ctrl.sv
module flashbus_ctrl
   import flashbus_pkg::*;
#(
   parameter int         ADDR_W       = 4,
   parameter int         BLK_AW       = 1,
   parameter int         READ_WAKE    = 3,
   parameter int         WRITE_WAKE   = 10,
   parameter int         PROG_CYC     = 5,
   parameter int         ERASE_CYC    = 12,
   parameter bit         BOOT_TOP     = 1'b1,
   parameter logic [7:0] INVALID_BYTE = 8'h00
) (
   input  logic              clk,
   input  logic              rp_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              vpp_ok,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        din,
   output logic [7:0]        dout,
   output logic              dout_en,
   output logic [2:0]        bus_mode
);
   logic              rd_ok;
   logic              wr_ok;
   bus_mode_t         mode;
   rd_src_t           rd_src;
   logic [BYTE_W-1:0] status;
   logic              commit_prog;
   logic              commit_erase;
   logic              abort;
   logic [ADDR_W-1:0] op_addr;
   logic [BYTE_W-1:0] op_data;

   flashbus_wake_cnt #(.LIMIT(READ_WAKE)) u_rd_wake (
      .clk(clk), .rp_n(rp_n), .ok(rd_ok));

   flashbus_wake_cnt #(.LIMIT(WRITE_WAKE)) u_wr_wake (
      .clk(clk), .rp_n(rp_n), .ok(wr_ok));

   flashbus_mode_dec u_dec (
      .rp_n(rp_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .rd_ok(rd_ok), .mode(mode), .drive(dout_en));

   flashbus_cmd_fsm #(
      .ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
   ) u_fsm (
      .clk(clk), .rp_n(rp_n), .ce_n(ce_n), .we_n(we_n), .vpp_ok(vpp_ok),
      .wr_ok(wr_ok), .addr(addr), .din(din), .rd_src(rd_src),
      .status(status), .commit_prog(commit_prog),
      .commit_erase(commit_erase), .abort(abort),
      .op_addr(op_addr), .op_data(op_data));

   flashbus_store #(
      .ADDR_W(ADDR_W), .BLK_AW(BLK_AW), .BOOT_TOP(BOOT_TOP),
      .INVALID_BYTE(INVALID_BYTE)
   ) u_store (
      .clk(clk), .rp_n(rp_n), .addr(addr), .rd_src(rd_src),
      .status(status), .commit_prog(commit_prog),
      .commit_erase(commit_erase), .abort(abort),
      .op_addr(op_addr), .op_data(op_data), .rdata(dout));

   assign bus_mode = mode;

   // R3
   standby_hiz_chk: assert property (@(posedge clk) disable iff (!rp_n)
      ce_n |-> !dout_en);

   // R2
   oe_hiz_chk: assert property (@(posedge clk) disable iff (!rp_n)
      oe_n |-> !dout_en);
endmodule

// File: tb/flashbus_ctrl_bench.sv
module flashbus_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW   = 4;
   localparam int RW   = 3;
   localparam int WW   = 10;
   localparam int PC   = 5;
   localparam int EC   = 12;
   localparam int NB   = 1 << AW;
   localparam logic [7:0] INV = 8'h00;

   logic clk = 1'b0;
   logic rp_n = 1'b0, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, vpp_ok = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [7:0] din = 8'hFF;
   logic [7:0] dout;
   logic dout_en;
   logic [2:0] bus_mode;

   int checks = 0;
   int errors = 0;
   logic [7:0] model [NB];
   logic [1:0] mvalid = 2'b00;

   always #(CLK_PERIOD/2) clk = ~clk;

   flashbus_ctrl #(.ADDR_W(AW), .BLK_AW(1), .READ_WAKE(RW),
      .WRITE_WAKE(WW), .PROG_CYC(PC), .ERASE_CYC(EC), .BOOT_TOP(1'b1),
      .INVALID_BYTE(INV)) u_flashbus_ctrl (
      .clk(clk), .rp_n(rp_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .vpp_ok(vpp_ok), .addr(addr), .din(din), .dout(dout),
      .dout_en(dout_en), .bus_mode(bus_mode));

   function automatic logic [2:0] exp_mode(logic r, logic c, logic o, logic w);
      if (!r) return 3'd0;
      if (c)  return 3'd1;
      if (!w) return 3'd4;
      if (o)  return 3'd2;
      return 3'd3;
   endfunction

   function automatic logic [7:0] exp_array(logic [AW-1:0] a);
      return mvalid[a[AW-1]] ? model[a] : INV;
   endfunction

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [AW-1:0] a, logic [7:0] d);
      @(negedge clk);
      oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0; addr = a; din = d;
      @(negedge clk);
      we_n = 1'b1;
      @(negedge clk);
      ce_n = 1'b1;
   endtask

   task automatic rd(logic [AW-1:0] a, output logic [7:0] v, output logic en);
      @(negedge clk);
      we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0; addr = a;
      #1;
      v = dout; en = dout_en;
   endtask

   task automatic rd_chk(string req, logic [AW-1:0] a, logic [7:0] exp);
      logic [7:0] v;
      logic en;
      rd(a, v, en);
      chk(req, {7'd0, en}, 8'd1);
      chk(req, v, exp);
   endtask

   task automatic erase_blk(logic b);
      wr({b, {(AW-1){1'b0}}}, 8'h20);
      repeat (EC + 2) @(negedge clk);
   endtask

   task automatic wake_up();
      @(negedge clk);
      rp_n = 1'b1;
      repeat (WW + 2) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      logic [7:0] v;
      logic en;
      void'($urandom(32'h5EED_0042));

      // R4: power-down state
      repeat (3) @(negedge clk);
      #1;
      chk("R4 en", {7'd0, dout_en}, 8'd0);
      chk("R4 mode", {5'd0, bus_mode}, 8'd0);
      ce_n = 1'b0; oe_n = 1'b0; #1;
      chk("R4 en with strobes", {7'd0, dout_en}, 8'd0);
      ce_n = 1'b1; oe_n = 1'b1;
      wake_up();

      // R5: array is the power-up read source, R9 erase both blocks
      erase_blk(1'b0);
      erase_blk(1'b1);
      for (int i = 0; i < NB; i++) model[i] = 8'hFF;
      mvalid = 2'b11;
      rd_chk("R7 status after erase", 0, 8'h80);
      wr(0, 8'hFF);
      for (int i = 0; i < NB; i++) rd_chk("R9 erased", AW'(i), 8'hFF);

      // R8: random byte programs, status busy while running
      for (int n = 0; n < 16; n++) begin
         logic [AW-1:0] a;
         logic [7:0] d;
         a = AW'($urandom_range(0, NB-1));
         d = 8'($urandom);
         wr(a, 8'h40);
         rd_chk("R8 armed status", a, 8'h80);
         wr(a, d);
         rd_chk("R8 busy status", a, 8'h00);
         wr(a, 8'hFF);
         repeat (PC) @(negedge clk);
         rd_chk("R8 write ignored while busy", a, 8'h80);
         model[a] = d;
      end
      wr(0, 8'hFF);
      for (int i = 0; i < NB; i++) rd_chk("R8 readback", AW'(i), model[i]);

      // R6: identifier codes
      wr(5, 8'h90);
      rd_chk("R6 mfr", 4'd0, 8'h89);
      rd_chk("R6 dev", 4'd1, 8'h94);
      rd_chk("R6 mfr upper addr", 4'd14, 8'h89);
      rd_chk("R6 dev upper addr", 4'd11, 8'h94);
      wr(0, 8'h70);
      rd_chk("R5 status source", 4'd3, 8'h80);
      wr(0, 8'hFF);
      rd_chk("R5 array source", 4'd3, model[3]);

      // R1 R2 R3: random pin patterns against the decode model
      for (int n = 0; n < 60; n++) begin
         logic c, o, w;
         @(negedge clk);
         c = 1'($urandom); o = 1'($urandom); w = 1'($urandom);
         din = 8'hFF; addr = AW'($urandom);
         ce_n = c; oe_n = o; we_n = w;
         #1;
         chk("R1 mode", {5'd0, bus_mode}, {5'd0, exp_mode(1'b1, c, o, w)});
         chk("R1 R2 R3 enable", {7'd0, dout_en},
             {7'd0, exp_mode(1'b1, c, o, w) == 3'd3});
         if (dout_en) chk("R1 data", dout, exp_array(addr));
      end
      @(negedge clk);
      ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;

      // R10: refused program and erase with low program voltage
      vpp_ok = 1'b0;
      wr(4'd2, 8'h40);
      wr(4'd2, 8'h3C);
      rd_chk("R10 status error", 4'd2, 8'h88);
      wr(4'd9, 8'h20);
      repeat (EC + 2) @(negedge clk);
      wr(0, 8'hFF);
      rd_chk("R10 program refused", 4'd2, model[2]);
      rd_chk("R10 erase refused", 4'd9, model[9]);
      wr(0, 8'h50);
      wr(0, 8'h70);
      rd_chk("R7 clear error", 4'd0, 8'h80);
      vpp_ok = 1'b1;

      // R11: deselected for the whole program
      wr(4'd6, 8'h40);
      wr(4'd6, 8'hA5);
      @(negedge clk); #1;
      chk("R11 standby during op", {5'd0, bus_mode}, 8'd1);
      repeat (PC + 2) @(negedge clk);
      model[6] = 8'hA5;
      wr(0, 8'hFF);
      rd_chk("R11 op completed", 4'd6, 8'hA5);

      // R12 R7 R13 R14: power-down in the middle of an erase
      vpp_ok = 1'b0;
      wr(0, 8'h40);
      wr(0, 8'h11);
      vpp_ok = 1'b1;
      wr(4'd12, 8'h20);
      repeat (3) @(negedge clk);
      rp_n = 1'b0;
      ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = 0;
      repeat (2) @(negedge clk);
      mvalid[1] = 1'b0;
      rp_n = 1'b1;
      for (int k = 1; k <= RW + 1; k++) begin
         @(negedge clk); #1;
         chk("R13 wake enable", {7'd0, dout_en}, {7'd0, k >= RW});
      end
      wr(4'd9, 8'h70);
      rd_chk("R14 R12 R7 early cmd ignored, aborted block", 4'd9, INV);
      rd_chk("R12 other block intact", 4'd6, model[6]);
      repeat (WW) @(negedge clk);
      wr(0, 8'h70);
      rd_chk("R7 status after wake", 4'd0, 8'h80);
      erase_blk(1'b1);
      for (int i = NB/2; i < NB; i++) model[i] = 8'hFF;
      mvalid[1] = 1'b1;
      wr(0, 8'hFF);
      rd_chk("R12 R9 block restored", 4'd12, 8'hFF);
      rd_chk("R12 R9 block restored", 4'd8, 8'hFF);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule